// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Unit

This unit holds the software-visible control and status state for three DMA channels (line input, playback output and microphone input) together with a global control word and a global status word. It decodes byte, halfword and word register accesses on a simple access port. The channel sequencers drive its event inputs, and it returns run levels, descriptor-fetch strobes and reset-request strobes to them. It drives one level-sensitive interrupt line.

Each channel has a 16-byte register group: channel 0 at 0x00, channel 1 at 0x10 and channel 2 at 0x20. The global control word sits at 0x2c and the global status word at 0x30. Within a group, the offsets are base address at 0, current index at 4, last-valid index at 5, status at 6, remaining count at 8, prefetch index at 10 and control at 11. A register read is combinational on the access address. A write takes effect at the clock edge that samples it, and a strobe it causes is high for the cycle after that edge. The codec link and the data movement itself lie outside this unit.

The interrupt line is a single register. It is re-evaluated only in a cycle where the set of pending bits (status bits 4..2) of some channel changes. When the set becomes empty the line drops. Otherwise the line rises if a pending bit is paired with its enable. A change that qualifies neither way leaves the line as it was.

Top module: `dma_stat_irq`

## Requirements
- R1: After reset, every channel status reads 0x01 (halted only), every other channel field reads 0, the global control reads 0, the global status reads 0x00000100, and `irq` and `ch_run` are 0.
- R2: In channel status, bit 4 (FIFO error), bit 3 (buffer complete) and bit 2 (last buffer complete) are cleared by writing 1 through a byte or halfword write at offset 6. Bit 1 (current equals last) and bit 0 (halted) are not changed by such writes. Writing 0 changes nothing.
- R3: A byte write at control offset 11 with bit 1 clear stores bits 4..0. Bit 0 (run) appears on `ch_run`. If run is 0, halted is set. If run is 1, current index takes the prefetch index, prefetch increments modulo 32, halted clears and `ch_fetch` pulses.
- R4: A control write with bit 1 set clears the base, the indices, the remaining count and control bits 1..0, keeps control bits 4..2, sets status to exactly 0x01 and pulses `ch_reset`. If pending bits were set, the interrupt drops.
- R5: A byte write at offset 5 stores bits 4..0 as the last-valid index. If run is set and halted is set, it also clears halted and current-equals-last, advances the indices as in R3 and pulses `ch_fetch`.
- R6: When a channel's pending set changes to a nonzero value, `irq` is set if (bit 2 and control bit 2) or (bit 3 and control bit 4) holds. The same event sets global status bit 5+channel. FIFO error alone never asserts.
- R7: When a channel's pending set becomes empty, `irq` clears and global status bit 5+channel clears. A pending change that is nonzero but does not qualify, and any enable change, leave `irq` unchanged.
- R8: A word read at offset 4 returns current | last<<8 | status<<16. A word read at offset 8 returns remaining | prefetch<<16 | control<<24. Byte reads are defined at offsets 4, 5, 6, 10 and 11, halfword reads at offsets 6 and 8, and word reads at offsets 0, 4 and 8. Each returns the field zero-extended.
- R9: A word write of the global control at 0x2c is ignored when bit 2 or bit 1 of the data is set. Otherwise bits 5..0 are stored.
- R10: A word write of the global status at 0x30 clears bits 15, 11, 10 and 0 where the data is 1 and sets bits 17 and 16 where the data is 1. It does not change any other bit. Global status reads always have bit 8 set.
- R11: Any access at an undecoded address, with a wrong size, with `acc_size`=3, or with address bits above bit 5 set reads 0xFFFFFFFF and writes nothing.
- R12: A word write of the base address clears data bits 1..0. The sequencer inputs `seq_set`, `seq_clr` (bits 1..0), `seq_adv` (current takes prefetch, prefetch increments) and `seq_cnt_we` act after any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access valid |
| acc_we | input | 1 | Access is a write |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 32 | Write data, right-aligned |
| acc_rdata | output | 32 | Read data for `acc_addr` and `acc_size` |
| seq_set | input | 15 | Per channel, status bits to set (5 per channel) |
| seq_clr | input | 6 | Per channel, clears for status bits 1..0 |
| seq_adv | input | 3 | Per channel, advance indices |
| seq_cnt_we | input | 3 | Per channel, load remaining count |
| seq_cnt | input | 48 | Per channel, remaining count value |
| ch_run | output | 3 | Per channel, control run bit |
| ch_fetch | output | 3 | Per channel, descriptor fetch strobe |
| ch_reset | output | 3 | Per channel, reset-request strobe |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is an asserted interrupt that has to stay high across a pending-set change that no longer qualifies. Reaching it takes several steps. First, assert through last-buffer-complete with its enable set. Next, clear that enable with a control write, which does not re-evaluate the line. Then add a FIFO error through the sequencer input, and after that clear one pending bit at a time. An exhaustive sweep over every enable combination and every nonzero pending set on all three channels covers the qualify and no-qualify decisions. Runs of 34 consecutive run writes carry the prefetch index through its wrap.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

    localparam int NCH    = 3;
    localparam int IDX_W  = 5;
    localparam int CNT_W  = 16;
    localparam int STS_W  = 5;
    localparam int CTL_W  = 5;
    localparam int GCTL_W = 6;
    localparam int GSTA_W = 18;

    // channel status bit positions
    localparam int ST_FIFO = 4;
    localparam int ST_DONE = 3;
    localparam int ST_LAST = 2;
    localparam int ST_CEQ  = 1;
    localparam int ST_HALT = 0;

    // channel control bit positions
    localparam int CT_DONE_EN = 4;
    localparam int CT_FIFO_EN = 3;
    localparam int CT_LAST_EN = 2;
    localparam int CT_RESET   = 1;
    localparam int CT_RUN     = 0;

    localparam logic [CTL_W-1:0]  CT_KEEP_MASK = 5'b11100;

    // offsets within a 16-byte channel group
    localparam logic [3:0] OFF_BASE = 4'd0;
    localparam logic [3:0] OFF_CUR  = 4'd4;
    localparam logic [3:0] OFF_LAST = 4'd5;
    localparam logic [3:0] OFF_STS  = 4'd6;
    localparam logic [3:0] OFF_CNT  = 4'd8;
    localparam logic [3:0] OFF_PRE  = 4'd10;
    localparam logic [3:0] OFF_CTL  = 4'd11;

    localparam logic [5:0] GADDR_CTL = 6'h2c;
    localparam logic [5:0] GADDR_STA = 6'h30;

    // global status masks
    localparam logic [GSTA_W-1:0] GS_W1C   = 18'h08C01;
    localparam logic [GSTA_W-1:0] GS_SET   = 18'h30000;
    localparam logic [GSTA_W-1:0] GS_READY = 18'h00100;
    localparam int                GS_CH0   = 5;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_X = 2'd3
    } acc_sz_e;

    typedef struct packed {
        logic [31:0]      base;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] pre;
        logic [STS_W-1:0] sts;
        logic [CNT_W-1:0] cnt;
        logic [CTL_W-1:0] ctl;
    } chan_t;

    typedef struct packed {
        logic wr_base;
        logic wr_last;
        logic wr_sts;
        logic wr_ctl;
    } chan_wr_t;

    function automatic chan_t chan_reset_val();
        chan_t c;
        c = '0;
        c.sts[ST_HALT] = 1'b1;
        return c;
    endfunction

    function automatic logic irq_qualifies(logic [STS_W-1:0] s, logic [CTL_W-1:0] c);
        return (s[ST_LAST] & c[CT_LAST_EN]) | (s[ST_DONE] & c[CT_DONE_EN]);
    endfunction

endpackage

// File: rtl/dsi_chan.sv
module dsi_chan
    import dsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_wr_t         wr,
    input  logic [31:0]      wdata,
    input  logic [STS_W-1:0] seq_set,
    input  logic [1:0]       seq_clr,
    input  logic             seq_adv,
    input  logic             seq_cnt_we,
    input  logic [CNT_W-1:0] seq_cnt,
    output chan_t            q,
    output logic             run,
    output logic             fetch,
    output logic             rst_req,
    output logic             ev_on,
    output logic             ev_off
);

    chan_t n;
    logic  fetch_n, rreq_n;
    logic [2:0] pend_old, pend_new;

    always_comb begin
        n       = q;
        fetch_n = 1'b0;
        rreq_n  = 1'b0;
        if (wr.wr_base)
            n.base = {wdata[31:2], 2'b00};
        if (wr.wr_last) begin
            if (q.ctl[CT_RUN] && q.sts[ST_HALT]) begin
                n.sts[ST_HALT] = 1'b0;
                n.sts[ST_CEQ]  = 1'b0;
                n.cur          = q.pre;
                n.pre          = q.pre + 1'b1;
                fetch_n        = 1'b1;
            end
            n.last = wdata[IDX_W-1:0];
        end
        if (wr.wr_ctl) begin
            if (wdata[CT_RESET]) begin
                n      = chan_reset_val();
                n.ctl  = q.ctl & CT_KEEP_MASK;
                rreq_n = 1'b1;
            end else begin
                n.ctl = wdata[CTL_W-1:0];
                if (!wdata[CT_RUN]) begin
                    n.sts[ST_HALT] = 1'b1;
                end else begin
                    n.cur          = q.pre;
                    n.pre          = q.pre + 1'b1;
                    n.sts[ST_HALT] = 1'b0;
                    fetch_n        = 1'b1;
                end
            end
        end
        if (wr.wr_sts)
            n.sts[ST_FIFO:ST_LAST] = q.sts[ST_FIFO:ST_LAST] & ~wdata[ST_FIFO:ST_LAST];
        // sequencer events land on top of any register write
        n.sts[ST_CEQ:ST_HALT] = n.sts[ST_CEQ:ST_HALT] & ~seq_clr;
        n.sts = n.sts | seq_set;
        if (seq_adv) begin
            n.cur = n.pre;
            n.pre = n.pre + 1'b1;
        end
        if (seq_cnt_we)
            n.cnt = seq_cnt;
    end

    assign pend_old = q.sts[ST_FIFO:ST_LAST];
    assign pend_new = n.sts[ST_FIFO:ST_LAST];
    assign ev_off   = (pend_old != pend_new) && (pend_new == 3'b000);
    assign ev_on    = (pend_old != pend_new) && (pend_new != 3'b000)
                      && irq_qualifies(n.sts, n.ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= chan_reset_val();
            fetch   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            q       <= n;
            fetch   <= fetch_n;
            rst_req <= rreq_n;
        end
    end

    assign run = q.ctl[CT_RUN];

endmodule

// File: rtl/dsi_glob.sv
module dsi_glob
    import dsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_sta,
    input  logic [GSTA_W-1:0] wdata,
    input  logic [NCH-1:0]    ch_on,
    input  logic [NCH-1:0]    ch_off,
    output logic [GCTL_W-1:0] gctl,
    output logic [GSTA_W-1:0] gsta,
    output logic              irq
);

    logic [GSTA_W-1:0] gsta_n;
    logic              irq_n;

    always_comb begin
        gsta_n = gsta;
        if (wr_sta) begin
            gsta_n = gsta_n & ~(wdata & GS_W1C);
            gsta_n = gsta_n | (wdata & GS_SET);
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_on[i])
                gsta_n[GS_CH0+i] = 1'b1;
            else if (ch_off[i])
                gsta_n[GS_CH0+i] = 1'b0;
        end
        if (|ch_on)
            irq_n = 1'b1;
        else if (|ch_off)
            irq_n = 1'b0;
        else
            irq_n = irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gctl <= '0;
            gsta <= '0;
            irq  <= 1'b0;
        end else begin
            if (wr_ctl && !(wdata[2] || wdata[1]))
                gctl <= wdata[GCTL_W-1:0];
            gsta <= gsta_n;
            irq  <= irq_n;
        end
    end

endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq
    import dsi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_en,
    input  logic                 acc_we,
    input  logic [1:0]           acc_size,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    input  logic [NCH*STS_W-1:0] seq_set,
    input  logic [NCH*2-1:0]     seq_clr,
    input  logic [NCH-1:0]       seq_adv,
    input  logic [NCH-1:0]       seq_cnt_we,
    input  logic [NCH*CNT_W-1:0] seq_cnt,
    output logic [NCH-1:0]       ch_run,
    output logic [NCH-1:0]       ch_fetch,
    output logic [NCH-1:0]       ch_reset,
    output logic                 irq
);

    localparam int GRP_LSB = 4;

    acc_sz_e      sz;
    logic         wr_go, up_ok;
    logic [1:0]   grp;
    logic [3:0]   off;
    chan_wr_t     cw [NCH];
    chan_t        cq [NCH];
    logic [NCH-1:0] ev_on, ev_off;
    logic [NCH*3-1:0] pend_all;
    logic [GCTL_W-1:0] gctl_q;
    logic [GSTA_W-1:0] gsta_q;
    logic         g_ctl_wr, g_sta_wr;

    assign sz    = acc_sz_e'(acc_size);
    assign wr_go = acc_en && acc_we;
    assign up_ok = (acc_addr[ADDR_W-1:6] == '0);
    assign grp   = acc_addr[5:GRP_LSB];
    assign off   = acc_addr[GRP_LSB-1:0];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            logic sel;
            sel = wr_go && up_ok && (grp == 2'(i));
            cw[i].wr_base = sel && (sz == SZ_W) && (off == OFF_BASE);
            cw[i].wr_last = sel && (sz == SZ_B) && (off == OFF_LAST);
            cw[i].wr_ctl  = sel && (sz == SZ_B) && (off == OFF_CTL);
            cw[i].wr_sts  = sel && ((sz == SZ_B) || (sz == SZ_H)) && (off == OFF_STS);
        end
    end

    assign g_ctl_wr = wr_go && up_ok && (sz == SZ_W) && (acc_addr[5:0] == GADDR_CTL);
    assign g_sta_wr = wr_go && up_ok && (sz == SZ_W) && (acc_addr[5:0] == GADDR_STA);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dsi_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr         (cw[g]),
            .wdata      (acc_wdata),
            .seq_set    (seq_set[g*STS_W +: STS_W]),
            .seq_clr    (seq_clr[g*2 +: 2]),
            .seq_adv    (seq_adv[g]),
            .seq_cnt_we (seq_cnt_we[g]),
            .seq_cnt    (seq_cnt[g*CNT_W +: CNT_W]),
            .q          (cq[g]),
            .run        (ch_run[g]),
            .fetch      (ch_fetch[g]),
            .rst_req    (ch_reset[g]),
            .ev_on      (ev_on[g]),
            .ev_off     (ev_off[g])
        );
        assign pend_all[g*3 +: 3] = cq[g].sts[ST_FIFO:ST_LAST];
    end

    dsi_glob u_glob (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (g_ctl_wr),
        .wr_sta (g_sta_wr),
        .wdata  (acc_wdata[GSTA_W-1:0]),
        .ch_on  (ev_on),
        .ch_off (ev_off),
        .gctl   (gctl_q),
        .gsta   (gsta_q),
        .irq    (irq)
    );

    always_comb begin
        acc_rdata = '1;
        for (int i = 0; i < NCH; i++) begin
            if (up_ok && (grp == 2'(i))) begin
                case (sz)
                    SZ_B: case (off)
                        OFF_CUR:  acc_rdata = {27'b0, cq[i].cur};
                        OFF_LAST: acc_rdata = {27'b0, cq[i].last};
                        OFF_STS:  acc_rdata = {27'b0, cq[i].sts};
                        OFF_PRE:  acc_rdata = {27'b0, cq[i].pre};
                        OFF_CTL:  acc_rdata = {27'b0, cq[i].ctl};
                        default:  ;
                    endcase
                    SZ_H: case (off)
                        OFF_STS:  acc_rdata = {27'b0, cq[i].sts};
                        OFF_CNT:  acc_rdata = {16'b0, cq[i].cnt};
                        default:  ;
                    endcase
                    SZ_W: case (off)
                        OFF_BASE: acc_rdata = cq[i].base;
                        OFF_CUR:  acc_rdata = {11'b0, cq[i].sts, 3'b0, cq[i].last, 3'b0, cq[i].cur};
                        OFF_CNT:  acc_rdata = {3'b0, cq[i].ctl, 3'b0, cq[i].pre, cq[i].cnt};
                        default:  ;
                    endcase
                    default: ;
                endcase
            end
        end
        if (up_ok && (sz == SZ_W) && (acc_addr[5:0] == GADDR_CTL))
            acc_rdata = {26'b0, gctl_q};
        if (up_ok && (sz == SZ_W) && (acc_addr[5:0] == GADDR_STA))
            acc_rdata = {14'b0, gsta_q | GS_READY};
    end

endmodule

// File: rtl/dma_stat_irq_chk.sv
module dma_stat_irq_chk
    import dsi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic [NCH-1:0]    ch_run,
    input logic [NCH-1:0]    ch_fetch,
    input logic [NCH-1:0]    ch_reset,
    input logic [GSTA_W-1:0] gsta,
    input logic [NCH*3-1:0]  pend
);

    // R1: the cycle after reset leaves everything idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && ch_run == '0 && gsta == '0));

    // R6: a rising interrupt always comes with a channel flag in global status
    a_r6_rise_flags: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (gsta[GS_CH0+2:GS_CH0] != 3'b000));

    // R7: a falling interrupt means some channel's pending set just emptied
    a_r7_fall_on_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> (($past(pend[2:0]) != 3'b000 && pend[2:0] == 3'b000) ||
                        ($past(pend[5:3]) != 3'b000 && pend[5:3] == 3'b000) ||
                        ($past(pend[8:6]) != 3'b000 && pend[8:6] == 3'b000)));

    for (genvar g = 0; g < NCH; g++) begin : g_p
        // R3: a fetch strobe is only issued for a running channel
        a_r3_fetch_runs: assert property (@(posedge clk) disable iff (rst)
            ch_fetch[g] |-> ch_run[g]);
        // R4: a reset request leaves the channel stopped
        a_r4_reset_stops: assert property (@(posedge clk) disable iff (rst)
            ch_reset[g] |-> !ch_run[g]);
    end

endmodule

bind dma_stat_irq dma_stat_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .ch_run   (ch_run),
    .ch_fetch (ch_fetch),
    .ch_reset (ch_reset),
    .gsta     (gsta_q),
    .pend     (pend_all)
);

// File: tb/sim_dma_stat_irq.sv
`timescale 1ns/1ps
module sim_dma_stat_irq;
    import dsi_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_we = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0, acc_rdata;
    logic [14:0] seq_set = '0;
    logic [5:0]  seq_clr = '0;
    logic [2:0]  seq_adv = '0, seq_cnt_we = '0;
    logic [47:0] seq_cnt = '0;
    logic [2:0]  ch_run, ch_fetch, ch_reset;
    logic        irq;

    int total = 0, bad = 0;
    logic [2:0]  got_fetch, got_rst;
    logic [31:0] d;

    always #10 clk = ~clk;

    dma_stat_irq #(.ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .seq_set(seq_set), .seq_clr(seq_clr), .seq_adv(seq_adv),
        .seq_cnt_we(seq_cnt_we), .seq_cnt(seq_cnt), .ch_run(ch_run),
        .ch_fetch(ch_fetch), .ch_reset(ch_reset), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_size = s; acc_wdata = v;
        @(posedge clk);
        #1;
        got_fetch = ch_fetch;
        got_rst   = ch_reset;
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a; acc_size = s;
        #5;
        v = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic seq_ev(input int ch, input logic [4:0] st, input logic [1:0] cl,
                          input logic adv, input logic cwe, input logic [15:0] cnt);
        @(negedge clk);
        seq_set[ch*5 +: 5] = st;
        seq_clr[ch*2 +: 2] = cl;
        seq_adv[ch]        = adv;
        seq_cnt_we[ch]     = cwe;
        seq_cnt[ch*16 +: 16] = cnt;
        @(posedge clk);
        #1;
        got_fetch = ch_fetch;
        seq_set = '0; seq_clr = '0; seq_adv = '0; seq_cnt_we = '0;
    endtask

    function automatic logic [7:0] ca(input int ch, input int o);
        return 8'(ch * 16 + o);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-reqs got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] gexp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int ch = 0; ch < 3; ch++) begin
            rd(ca(ch, 6), 2'd1, d); chk("R1 status", d, 32'h1);
            rd(ca(ch, 0), 2'd2, d); chk("R1 base", d, 32'h0);
            rd(ca(ch, 4), 2'd2, d); chk("R1 word4", d, 32'h0001_0000);
            rd(ca(ch, 8), 2'd2, d); chk("R1 word8", d, 32'h0);
        end
        rd(8'h30, 2'd2, d); chk("R1 gsta", d, 32'h100);
        rd(8'h2c, 2'd2, d); chk("R1 gctl", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 run", {29'b0, ch_run}, 32'h0);

        // R6 / R7 sweep: every enable set against every nonzero pending set
        for (int ch = 0; ch < 3; ch++) begin
            for (int e = 0; e < 8; e++) begin
                for (int p = 1; p < 8; p++) begin
                    logic asrt;
                    asrt = (p[0] & e[0]) | (p[1] & e[2]);
                    wr(ca(ch, 11), 2'd0, 32'(e << 2));
                    seq_ev(ch, 5'(p << 2), 2'b00, 1'b0, 1'b0, 16'h0);
                    chk("R6 irq", {31'b0, irq}, {31'b0, asrt});
                    rd(8'h30, 2'd2, d);
                    chk("R6 gsta", d, 32'h100 | (32'(asrt) << (5 + ch)));
                    wr(ca(ch, 6), 2'd0, 32'h1c);
                    chk("R7 irq drop", {31'b0, irq}, 32'h0);
                    rd(8'h30, 2'd2, d); chk("R7 gsta", d, 32'h100);
                    rd(ca(ch, 6), 2'd0, d); chk("R2 w1c all", d, 32'h1);
                end
            end
        end

        // R7 hold on non-qualifying change
        wr(ca(1, 11), 2'd0, 32'h04);
        seq_ev(1, 5'h04, 2'b00, 1'b0, 1'b0, 16'h0);
        chk("R6 lvb assert", {31'b0, irq}, 32'h1);
        wr(ca(1, 11), 2'd0, 32'h00);
        chk("R7 enable off keeps", {31'b0, irq}, 32'h1);
        seq_ev(1, 5'h10, 2'b00, 1'b0, 1'b0, 16'h0);
        chk("R7 fifo add keeps", {31'b0, irq}, 32'h1);
        wr(ca(1, 6), 2'd0, 32'h04);
        chk("R7 partial clear keeps", {31'b0, irq}, 32'h1);
        rd(8'h30, 2'd2, d); chk("R7 gsta kept", d, 32'h140);
        wr(ca(1, 6), 2'd0, 32'h10);
        chk("R7 empty drops", {31'b0, irq}, 32'h0);
        rd(8'h30, 2'd2, d); chk("R7 gsta cleared", d, 32'h100);

        // R2 read-only and write-one-to-clear mix on channel 2
        wr(ca(2, 11), 2'd0, 32'h00);
        seq_ev(2, 5'h02, 2'b00, 1'b0, 1'b0, 16'h0);
        wr(ca(2, 6), 2'd0, 32'hff);
        rd(ca(2, 6), 2'd0, d); chk("R2 ro kept", d, 32'h03);
        seq_ev(2, 5'h1c, 2'b00, 1'b0, 1'b0, 16'h0);
        rd(ca(2, 6), 2'd0, d); chk("R12 seq set", d, 32'h1f);
        wr(ca(2, 6), 2'd1, 32'h0008);
        rd(ca(2, 6), 2'd1, d); chk("R2 half w1c", d, 32'h17);
        rd(ca(2, 6), 2'd0, d); chk("R8 byte sts", d, 32'h17);
        seq_ev(2, 5'h00, 2'b11, 1'b0, 1'b0, 16'h0);
        rd(ca(2, 6), 2'd0, d); chk("R12 seq clr", d, 32'h14);
        wr(ca(2, 6), 2'd0, 32'h14);
        rd(ca(2, 6), 2'd0, d); chk("R2 cleared", d, 32'h00);
        chk("R7 irq idle", {31'b0, irq}, 32'h0);

        // R12 sequencer advance on channel 2
        seq_ev(2, 5'h00, 2'b00, 1'b1, 1'b0, 16'h0);
        seq_ev(2, 5'h00, 2'b00, 1'b1, 1'b0, 16'h0);
        rd(ca(2, 4), 2'd0, d); chk("R12 adv cur", d, 32'd1);
        rd(ca(2, 10), 2'd0, d); chk("R12 adv pre", d, 32'd2);

        // R3 run writes with index wrap on channel 0
        wr(ca(0, 11), 2'd0, 32'h02);
        for (int k = 1; k <= 34; k++) begin
            wr(ca(0, 11), 2'd0, 32'h01);
            chk("R3 fetch", {29'b0, got_fetch}, 32'h1);
            chk("R3 run", {29'b0, ch_run}, 32'h1);
            rd(ca(0, 4), 2'd2, d); chk("R3 cur", d, 32'((k - 1) % 32));
            rd(ca(0, 8), 2'd2, d); chk("R3 pre", d, (32'(k % 32) << 16) | 32'h0100_0000);
        end
        wr(ca(0, 11), 2'd0, 32'h00);
        chk("R3 stop fetch", {29'b0, got_fetch}, 32'h0);
        chk("R3 stop run", {29'b0, ch_run}, 32'h0);
        rd(ca(0, 6), 2'd0, d); chk("R3 halted", d, 32'h01);

        // R5 last-valid writes
        wr(ca(0, 5), 2'd0, 32'h25);
        chk("R5 no fetch stopped", {29'b0, got_fetch}, 32'h0);
        rd(ca(0, 4), 2'd2, d); chk("R5 stopped", d, 32'h0001_0501);
        rd(ca(0, 5), 2'd0, d); chk("R8 byte last", d, 32'h05);
        wr(ca(0, 11), 2'd0, 32'h01);
        seq_ev(0, 5'h03, 2'b00, 1'b0, 1'b0, 16'h0);
        wr(ca(0, 5), 2'd0, 32'h07);
        chk("R5 restart fetch", {29'b0, got_fetch}, 32'h1);
        rd(ca(0, 4), 2'd2, d); chk("R5 restart", d, 32'h0000_0703);
        rd(ca(0, 10), 2'd0, d); chk("R5 pre", d, 32'h04);
        wr(ca(0, 5), 2'd0, 32'h09);
        chk("R5 running no fetch", {29'b0, got_fetch}, 32'h0);
        rd(ca(0, 4), 2'd2, d); chk("R5 running", d, 32'h0000_0903);

        // R12 base and count, R8 combined word
        wr(ca(0, 11), 2'd0, 32'h1d);
        seq_ev(0, 5'h00, 2'b00, 1'b0, 1'b1, 16'h1234);
        wr(ca(0, 0), 2'd2, 32'hDEAD_BEEF);
        rd(ca(0, 0), 2'd2, d); chk("R12 base", d, 32'hDEAD_BEEC);
        rd(ca(0, 8), 2'd1, d); chk("R8 half cnt", d, 32'h1234);
        rd(ca(0, 8), 2'd2, d); chk("R8 word8", d, 32'h1D05_1234);
        rd(ca(0, 11), 2'd0, d); chk("R8 byte ctl", d, 32'h1d);

        // R4 reset request
        seq_ev(0, 5'h08, 2'b00, 1'b0, 1'b0, 16'h0);
        chk("R6 done assert", {31'b0, irq}, 32'h1);
        wr(ca(0, 11), 2'd0, 32'h02);
        chk("R4 strobe", {29'b0, got_rst}, 32'h1);
        chk("R4 irq drop", {31'b0, irq}, 32'h0);
        chk("R4 run", {29'b0, ch_run}, 32'h0);
        rd(ca(0, 0), 2'd2, d); chk("R4 base", d, 32'h0);
        rd(ca(0, 4), 2'd2, d); chk("R4 word4", d, 32'h0001_0000);
        rd(ca(0, 8), 2'd2, d); chk("R4 word8", d, 32'h1C00_0000);

        // R9 global control sweep
        gexp = '0;
        for (int v = 0; v < 64; v++) begin
            wr(8'h2c, 2'd2, 32'hA5A5_A500 | 32'(v));
            if ((v & 6) == 0) gexp = 6'(v);
            rd(8'h2c, 2'd2, d); chk("R9 gctl", d, {26'b0, gexp});
        end

        // R10 global status
        wr(8'h30, 2'd2, 32'hFFFF_FFFF);
        rd(8'h30, 2'd2, d); chk("R10 set bits", d, 32'h0003_0100);
        wr(8'h30, 2'd2, 32'h0);
        rd(8'h30, 2'd2, d); chk("R10 zero write", d, 32'h0003_0100);
        wr(ca(1, 11), 2'd0, 32'h04);
        seq_ev(1, 5'h04, 2'b00, 1'b0, 1'b0, 16'h0);
        wr(8'h30, 2'd2, 32'h0000_00E0);
        rd(8'h30, 2'd2, d); chk("R10 ro channel bit", d, 32'h0003_0140);
        wr(ca(1, 6), 2'd0, 32'h04);
        rd(8'h30, 2'd2, d); chk("R10 after clear", d, 32'h0003_0100);

        // R11 undecoded
        rd(8'h3c, 2'd2, d); chk("R11 read 3c", d, 32'hFFFF_FFFF);
        rd(8'h01, 2'd0, d); chk("R11 read 01b", d, 32'hFFFF_FFFF);
        rd(8'h06, 2'd2, d); chk("R11 read 06w", d, 32'hFFFF_FFFF);
        rd(8'h04, 2'd1, d); chk("R11 read 04h", d, 32'hFFFF_FFFF);
        rd(8'h45, 2'd0, d); chk("R11 read high", d, 32'hFFFF_FFFF);
        rd(8'h04, 2'd3, d); chk("R11 size3", d, 32'hFFFF_FFFF);
        wr(8'h45, 2'd0, 32'h1f);
        rd(8'h05, 2'd0, d); chk("R11 high write", d, 32'h0);
        wr(8'h00, 2'd0, 32'hff);
        rd(8'h00, 2'd2, d); chk("R11 byte base", d, 32'h0);
        wr(8'h0b, 2'd1, 32'h01);
        chk("R11 half ctl", {29'b0, ch_run}, 32'h0);
        rd(8'h0b, 2'd0, d); chk("R11 ctl kept", d, 32'h1c);
        wr(8'h2c, 2'd0, 32'h3f);
        rd(8'h2c, 2'd2, d); chk("R11 gctl byte", d, {26'b0, gexp});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule